// File: doc/BRIEF.md
# Virtual Wire Handshake Responder

This block sits next to a bank of byte-wide virtual wire registers and answers host warnings and reset changes without firmware. Each byte keeps its level bits in bits 3:0 and the matching valid bits in bits 7:4. A wire's qualified value is its level bit ANDed with its valid bit. The block watches eight monitored indices, each tied to an update flag bit: bit 0 is 02h, bit 1 is 03h, bit 2 is 07h, bit 3 is 41h, bit 4 is 42h, bit 5 is 43h, bit 6 is 44h and bit 7 is 47h.

When a flagged index is serviced, the block XORs it against a stored snapshot to find which level bits changed. It then replaces the snapshot with the current byte. The changes drive acknowledge wires through read-modify-write cycles on the bank, load the startup byte into index 06h, and pulse event outputs. A separate request pulls the keyboard-controller reset wire low for a timed interval. The bank has a combinational read port and a write port that updates on the clock edge. The bank owner clears a flag when the block pulses the matching clear bit.

Top module: `vwr_responder`

## Requirements
- R1: After reset the block reads the eight monitored indices in flag-bit order, one per cycle, to seed its snapshots. During those eight cycles it clears no flag and writes nothing. A flag raised afterwards on an unchanged index produces no action.
- R2: Only indices whose update flag is set are serviced. One index is serviced per cycle, the lowest set flag bit first. Servicing pulses the matching `upd_clr_o` bit in that cycle. An index whose bytes changed while its flag stayed clear produces no action.
- R3: The changed bits are the snapshot XOR the current byte. The snapshot then takes the current value, so a repeated value produces no further action.
- R4: A level change on index 41h bit 0 writes the qualified value of that wire into index 40h bit 0. All other bits of 40h are kept. A change of the valid bit alone does nothing.
- R5: A level change on index 07h bit 0 writes its qualified value into index 06h bit 3. All other bits of 06h are kept.
- R6: A level change on index 03h bit 2 writes its qualified value into index 04h bit 0. All other bits of 04h are kept.
- R7: When index 03h bit 1 changes and its qualified value is 1 (reset released), index 06h is written with 8'hFF: four level bits at 1 and four valid bits at 1.
- R8: When index 03h bit 1 changes and its qualified value is 0 (reset asserted), `plt_rst_evt_o` pulses for one cycle. Index 06h is not written.
- R9: Each level change on index 02h bits 0, 1 and 2 pulses the matching bit of `pwr_evt_o` for one cycle, the cycle after the service.
- R10: A `host_rst_req_i` pulse clears index 06h bit 2. After exactly CLK_MHZ*PULSE_US cycles the block sets that bit again, keeping the other bits.
- R11: A request that arrives while a pulse is pending or active is ignored. A request after the pulse ends starts a new pulse.
- R12: A startup write during the low phase of the pulse writes 8'hFB, so the wire stays low until the timed release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vw_rd_idx_o | output | 8 | Bank read index |
| vw_rd_data_i | input | 8 | Bank byte at the read index, combinational |
| vw_wr_en_o | output | 1 | Bank write strobe |
| vw_wr_idx_o | output | 8 | Bank write index |
| vw_wr_data_o | output | 8 | Bank write byte |
| upd_flag_i | input | 8 | Update flags of the monitored indices |
| upd_clr_o | output | 8 | One-cycle clear for a serviced flag |
| host_rst_req_i | input | 1 | Request for a keyboard-controller reset pulse |
| pwr_evt_o | output | 3 | Change strobes for the three sleep wires |
| plt_rst_evt_o | output | 1 | Strobe when platform reset becomes asserted |

## Verification
A flag set at a clock edge is cleared in the next cycle, unless acknowledge writes are still draining. The event strobes follow one cycle after that clear. Each acknowledge or startup write takes one more cycle per pending item. The reset pulse's release lands exactly CLK_MHZ*PULSE_US cycles after its falling write. The bench records the cycle of every clear, every event and every change on the reset wire. It checks exact distances only where the design guarantees them: back-to-back clears and the pulse width. Bank contents and event totals are compared only after a settling margin longer than any write sequence.

// File: rtl/vwr_pkg.sv
package vwr_pkg;
  localparam int NSLOT  = 8;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int SNAP_W = 3;  // only level bits 2:0 feed any action

  localparam logic [7:0] IDX_OOB_ACK  = 8'h04;
  localparam logic [7:0] IDX_HOST_ACK = 8'h06;
  localparam logic [7:0] IDX_SUS_ACK  = 8'h40;

  localparam int SL_SLP   = 0;
  localparam int SL_RST   = 1;
  localparam int SL_HWARN = 2;
  localparam int SL_SWARN = 3;

  typedef enum logic {ST_INIT, ST_RUN} vwr_state_t;

  function automatic logic [7:0] slot_index(input logic [SLOT_W-1:0] s);
    case (s)
      3'd0:    slot_index = 8'h02;
      3'd1:    slot_index = 8'h03;
      3'd2:    slot_index = 8'h07;
      3'd3:    slot_index = 8'h41;
      3'd4:    slot_index = 8'h42;
      3'd5:    slot_index = 8'h43;
      3'd6:    slot_index = 8'h44;
      default: slot_index = 8'h47;
    endcase
  endfunction
endpackage

// File: rtl/vwr_pick.sv
module vwr_pick #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         vld_o,
  output logic [W-1:0] sel_o
);
  always_comb begin
    sel_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) sel_o = W'(i);
    end
  end
  assign vld_o = |req_i;
endmodule

// File: rtl/vwr_snap.sv
module vwr_snap #(
  parameter int N = 8,
  parameter int W = 3,
  localparam int SW = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SW-1:0]       sel_i,
  input  logic [W-1:0]        d_i,
  output logic [N-1:0][W-1:0] q_o
);
  for (genvar s = 0; s < N; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q_o[s] <= '0;
      else if (we_i && sel_i == SW'(s))    q_o[s] <= d_i;
    end
  end
endmodule

// File: rtl/vwr_pulse.sv
module vwr_pulse #(
  parameter int CYC = 2000,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic lo_ack_i,
  input  logic hi_ack_i,
  output logic lo_req_o,
  output logic hi_req_o,
  output logic low_o
);
  typedef enum logic [1:0] {P_IDLE, P_WLO, P_LOW} pst_t;
  pst_t st;
  logic [CW-1:0] cnt;

  assign lo_req_o = (st == P_WLO);
  assign low_o    = (st == P_LOW);
  assign hi_req_o = low_o && (cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st  <= P_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        P_IDLE: if (req_i) st <= P_WLO;
        P_WLO: if (lo_ack_i) begin
          st  <= P_LOW;
          cnt <= CW'(CYC - 1);
        end
        default: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          if (hi_ack_i) st <= P_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/vwr_responder.sv
module vwr_responder #(
  parameter int CLK_MHZ  = 200,
  parameter int PULSE_US = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  output logic [7:0]                vw_rd_idx_o,
  input  logic [7:0]                vw_rd_data_i,
  output logic                      vw_wr_en_o,
  output logic [7:0]                vw_wr_idx_o,
  output logic [7:0]                vw_wr_data_o,
  input  logic [vwr_pkg::NSLOT-1:0] upd_flag_i,
  output logic [vwr_pkg::NSLOT-1:0] upd_clr_o,
  input  logic                      host_rst_req_i,
  output logic [2:0]                pwr_evt_o,
  output logic                      plt_rst_evt_o
);
  import vwr_pkg::*;
  localparam int CYC = CLK_MHZ * PULSE_US;

  vwr_state_t st;
  logic [SLOT_W-1:0] init_cnt;
  logic [SLOT_W-1:0] sel;
  logic              sel_vld;
  logic [NSLOT-1:0][SNAP_W-1:0] snap;
  logic              snap_we;
  logic [SLOT_W-1:0] snap_sel;

  logic p_start, p_host, p_host_v, p_oob, p_oob_v, p_sus, p_sus_v;
  logic lo_req, hi_req, lo_ack, hi_ack, rcin_low;
  logic g_start, g_host, g_oob, g_sus;
  logic wr_any, svc;
  logic [SNAP_W-1:0] chg, qual;

  vwr_pick #(.N(NSLOT)) u_pick (
    .req_i (upd_flag_i),
    .vld_o (sel_vld),
    .sel_o (sel)
  );

  vwr_pulse #(.CYC(CYC)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (host_rst_req_i),
    .lo_ack_i (lo_ack),
    .hi_ack_i (hi_ack),
    .lo_req_o (lo_req),
    .hi_req_o (hi_req),
    .low_o    (rcin_low)
  );

  assign snap_we  = (st == ST_INIT) || svc;
  assign snap_sel = (st == ST_INIT) ? init_cnt : sel;

  vwr_snap #(.N(NSLOT), .W(SNAP_W)) u_snap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (snap_we),
    .sel_i  (snap_sel),
    .d_i    (vw_rd_data_i[SNAP_W-1:0]),
    .q_o    (snap)
  );

  assign wr_any = hi_req || lo_req || p_start || p_host || p_oob || p_sus;
  assign svc    = (st == ST_RUN) && !wr_any && sel_vld;
  assign chg    = snap[sel] ^ vw_rd_data_i[SNAP_W-1:0];
  assign qual   = vw_rd_data_i[SNAP_W-1:0] & vw_rd_data_i[SNAP_W+3:4];

  // one bank access per cycle: timed release, pulse start, startup, acks, service
  always_comb begin
    vw_rd_idx_o  = '0;
    vw_wr_en_o   = 1'b0;
    vw_wr_idx_o  = '0;
    vw_wr_data_o = '0;
    upd_clr_o    = '0;
    lo_ack = 1'b0; hi_ack = 1'b0;
    g_start = 1'b0; g_host = 1'b0; g_oob = 1'b0; g_sus = 1'b0;
    if (st == ST_INIT) begin
      vw_rd_idx_o = slot_index(init_cnt);
    end else if (hi_req) begin
      vw_rd_idx_o  = IDX_HOST_ACK;
      vw_wr_en_o   = 1'b1;
      vw_wr_idx_o  = IDX_HOST_ACK;
      vw_wr_data_o = vw_rd_data_i | 8'h04;
      hi_ack       = 1'b1;
    end else if (lo_req) begin
      vw_rd_idx_o  = IDX_HOST_ACK;
      vw_wr_en_o   = 1'b1;
      vw_wr_idx_o  = IDX_HOST_ACK;
      vw_wr_data_o = vw_rd_data_i & 8'hFB;
      lo_ack       = 1'b1;
    end else if (p_start) begin
      vw_rd_idx_o  = IDX_HOST_ACK;
      vw_wr_en_o   = 1'b1;
      vw_wr_idx_o  = IDX_HOST_ACK;
      vw_wr_data_o = rcin_low ? 8'hFB : 8'hFF;
      g_start      = 1'b1;
    end else if (p_host) begin
      vw_rd_idx_o  = IDX_HOST_ACK;
      vw_wr_en_o   = 1'b1;
      vw_wr_idx_o  = IDX_HOST_ACK;
      vw_wr_data_o = {vw_rd_data_i[7:4], p_host_v, vw_rd_data_i[2:0]};
      g_host       = 1'b1;
    end else if (p_oob) begin
      vw_rd_idx_o  = IDX_OOB_ACK;
      vw_wr_en_o   = 1'b1;
      vw_wr_idx_o  = IDX_OOB_ACK;
      vw_wr_data_o = {vw_rd_data_i[7:1], p_oob_v};
      g_oob        = 1'b1;
    end else if (p_sus) begin
      vw_rd_idx_o  = IDX_SUS_ACK;
      vw_wr_en_o   = 1'b1;
      vw_wr_idx_o  = IDX_SUS_ACK;
      vw_wr_data_o = {vw_rd_data_i[7:1], p_sus_v};
      g_sus        = 1'b1;
    end else if (svc) begin
      vw_rd_idx_o    = slot_index(sel);
      upd_clr_o[sel] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_INIT;
      init_cnt <= '0;
    end else if (st == ST_INIT) begin
      if (init_cnt == SLOT_W'(NSLOT - 1)) st <= ST_RUN;
      else init_cnt <= init_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_start <= 1'b0;
      p_host  <= 1'b0; p_host_v <= 1'b0;
      p_oob   <= 1'b0; p_oob_v  <= 1'b0;
      p_sus   <= 1'b0; p_sus_v  <= 1'b0;
      pwr_evt_o     <= '0;
      plt_rst_evt_o <= 1'b0;
    end else begin
      pwr_evt_o     <= '0;
      plt_rst_evt_o <= 1'b0;
      if (g_start) p_start <= 1'b0;
      if (g_host)  p_host  <= 1'b0;
      if (g_oob)   p_oob   <= 1'b0;
      if (g_sus)   p_sus   <= 1'b0;
      if (svc) begin
        case (int'(sel))
          SL_SLP: pwr_evt_o <= chg[2:0];
          SL_RST: begin
            if (chg[1]) begin
              if (qual[1]) p_start <= 1'b1;
              else         plt_rst_evt_o <= 1'b1;
            end
            if (chg[2]) begin
              p_oob   <= 1'b1;
              p_oob_v <= qual[2];
            end
          end
          SL_HWARN: if (chg[0]) begin
            p_host   <= 1'b1;
            p_host_v <= qual[0];
          end
          SL_SWARN: if (chg[0]) begin
            p_sus   <= 1'b1;
            p_sus_v <= qual[0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vwr_responder_chk.sv
module vwr_responder_chk (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      vw_wr_en_o,
  input logic [7:0]                vw_wr_idx_o,
  input logic [vwr_pkg::NSLOT-1:0] upd_flag_i,
  input logic [vwr_pkg::NSLOT-1:0] upd_clr_o,
  input logic [2:0]                pwr_evt_o,
  input logic                      plt_rst_evt_o
);
  logic [4:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= '0;
    else if (age != 5'h1F) age <= age + 1'b1;
  end

  a_r1_init_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age < 5'(vwr_pkg::NSLOT)) |-> (upd_clr_o == '0 && !vw_wr_en_o));

  a_r2_single_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(upd_clr_o));

  a_r2_clear_only_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_clr_o & ~upd_flag_i) == '0);

  a_r2_service_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|upd_clr_o) |-> !vw_wr_en_o);

  a_r9_slp_evt_after_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pwr_evt_o) |-> $past(upd_clr_o[0]));

  a_r8_rst_evt_after_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plt_rst_evt_o |-> $past(upd_clr_o[1]));

  a_r4_write_targets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vw_wr_en_o |-> (vw_wr_idx_o == 8'h04 || vw_wr_idx_o == 8'h06 || vw_wr_idx_o == 8'h40));
endmodule

bind vwr_responder vwr_responder_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .vw_wr_en_o    (vw_wr_en_o),
  .vw_wr_idx_o   (vw_wr_idx_o),
  .upd_flag_i    (upd_flag_i),
  .upd_clr_o     (upd_clr_o),
  .pwr_evt_o     (pwr_evt_o),
  .plt_rst_evt_o (plt_rst_evt_o)
);

// File: tb/vwr_responder_tb_top.sv
`timescale 1ns/1ps
module vwr_responder_tb_top;
  localparam int CLK_MHZ  = 2;
  localparam int PULSE_US = 10;
  localparam int CYC      = CLK_MHZ * PULSE_US;
  localparam int NS       = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic [7:0]    vw_rd_idx_o, vw_rd_data_i, vw_wr_idx_o, vw_wr_data_o;
  logic          vw_wr_en_o;
  logic [NS-1:0] upd_clr_o;
  logic [NS-1:0] flags = '0;
  logic          host_rst_req_i = 1'b0;
  logic [2:0]    pwr_evt_o;
  logic          plt_rst_evt_o;

  logic [7:0]    bank [256] = '{default: 8'h00};
  logic          tb_we = 1'b0;
  logic [7:0]    tb_idx = '0, tb_dat = '0;
  logic [NS-1:0] tb_raise = '0;
  int cyc = 0;

  vwr_responder #(.CLK_MHZ(CLK_MHZ), .PULSE_US(PULSE_US)) dut_i (
    .clk_i, .rst_ni, .vw_rd_idx_o, .vw_rd_data_i, .vw_wr_en_o, .vw_wr_idx_o,
    .vw_wr_data_o, .upd_flag_i(flags), .upd_clr_o, .host_rst_req_i,
    .pwr_evt_o, .plt_rst_evt_o
  );

  assign vw_rd_data_i = bank[vw_rd_idx_o];

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (tb_we) bank[tb_idx] <= tb_dat;
    if (vw_wr_en_o) bank[vw_wr_idx_o] <= vw_wr_data_o;
    flags <= (flags & ~upd_clr_o) | tb_raise;
  end

  int clr_n = 0, wr_n = 0, rst_n = 0, lo_n = 0, hi_n = 0, lo_cyc = 0, hi_cyc = 0;
  int pwr_n [3] = '{0, 0, 0};
  int clr_cyc [NS] = '{default: 0};
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int b = 0; b < NS; b++) if (upd_clr_o[b]) begin clr_n++; clr_cyc[b] = cyc; end
      for (int b = 0; b < 3; b++) if (pwr_evt_o[b]) pwr_n[b]++;
      if (plt_rst_evt_o) rst_n++;
      if (vw_wr_en_o) begin
        wr_n++;
        if (vw_wr_idx_o == 8'h06 && bank[6][2] && !vw_wr_data_o[2]) begin lo_n++; lo_cyc = cyc; end
        if (vw_wr_idx_o == 8'h06 && !bank[6][2] && vw_wr_data_o[2]) begin hi_n++; hi_cyc = cyc; end
      end
    end
  end

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk_i); tb_we = 1'b1; tb_idx = idx; tb_dat = val;
    @(negedge clk_i); tb_we = 1'b0;
  endtask

  task automatic raise(input logic [NS-1:0] m);
    @(negedge clk_i); tb_raise = m;
    @(negedge clk_i); tb_raise = '0;
  endtask

  task automatic post(input int slot, input logic [7:0] idx, input logic [7:0] val);
    put(idx, val);
    raise(NS'(1) << slot);
    repeat (8) @(negedge clk_i);
  endtask

  task automatic pulse_req();
    @(negedge clk_i); host_rst_req_i = 1'b1;
    @(negedge clk_i); host_rst_req_i = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int exp_p [3];
    int prev, l0, rst0;
    exp_p = '{0, 0, 0};
    put(8'h02, 8'h77); put(8'h03, 8'h70); put(8'h07, 8'h10);
    put(8'h41, 8'h10); put(8'h04, 8'h10); put(8'h40, 8'h10);
    @(negedge clk_i); rst_ni = 1'b1;
    check("R1 reset strobes", {29'd0, pwr_evt_o}, 0);
    repeat (NS + 3) @(negedge clk_i);
    check("R1 no write during init", wr_n, 0);
    check("R1 no clear during init", clr_n, 0);
    // R1 R3: snapshot seeded from current value, no change seen
    post(0, 8'h02, 8'h77);
    check("R1 flag serviced", clr_n, 1);
    check("R3 unchanged index gives no event", pwr_n[0] + pwr_n[1] + pwr_n[2], 0);

    // R9 R3: sweep all sleep-wire levels
    prev = 7;
    for (int v = 0; v < 8; v++) begin
      post(0, 8'h02, 8'(8'h70 | v));
      for (int b = 0; b < 3; b++) begin
        exp_p[b] += ((prev ^ v) >> b) & 1;
        check($sformatf("R9 slp bit %0d after value %0d", b, v), pwr_n[b], exp_p[b]);
      end
      prev = v;
    end

    // R4: suspend warning ack, valid qualifies, valid-only change ignored
    post(3, 8'h41, 8'h11); check("R4 ack high", bank[8'h40], 8'h11);
    post(3, 8'h41, 8'h01); check("R4 valid-only change ignored", bank[8'h40], 8'h11);
    post(3, 8'h41, 8'h00); check("R4 ack low", bank[8'h40], 8'h10);
    post(3, 8'h41, 8'h01); check("R4 invalid level qualifies low", bank[8'h40], 8'h10);
    post(3, 8'h41, 8'h11); check("R4 valid rise alone ignored", bank[8'h40], 8'h10);

    // R5 and R2 (unflagged change)
    post(2, 8'h07, 8'h11); check("R5 host ack high", bank[8'h06], 8'h08);
    post(2, 8'h07, 8'h10); check("R5 host ack low", bank[8'h06], 8'h00);
    put(8'h07, 8'h11); repeat (6) @(negedge clk_i);
    check("R2 unflagged index ignored", bank[8'h06], 8'h00);
    raise(8'h04); repeat (6) @(negedge clk_i);
    check("R2 flagged later serviced", bank[8'h06], 8'h08);

    // R6
    post(1, 8'h03, 8'h74); check("R6 oob ack high", bank[8'h04], 8'h11);
    post(1, 8'h03, 8'h70); check("R6 oob ack low", bank[8'h04], 8'h10);

    // R7 R8
    post(1, 8'h03, 8'h72);
    check("R7 startup byte", bank[8'h06], 8'hFF);
    check("R8 no event on release", rst_n, 0);
    post(1, 8'h03, 8'h70);
    check("R8 event on assertion", rst_n, 1);
    check("R8 no write on assertion", bank[8'h06], 8'hFF);

    // R2 ordering: flags 0,4,5 together, serviced on consecutive cycles
    put(8'h02, 8'h75); put(8'h42, 8'h03); put(8'h43, 8'h01);
    raise(8'b0011_0001); repeat (8) @(negedge clk_i);
    check("R2 slot4 one cycle after slot0", clr_cyc[4] - clr_cyc[0], 1);
    check("R2 slot5 two cycles after slot0", clr_cyc[5] - clr_cyc[0], 2);
    check("R9 slp bit 1 event in batch", pwr_n[1], exp_p[1] + 1);

    // R10 R11
    l0 = lo_n;
    pulse_req(); repeat (3) @(negedge clk_i);
    check("R10 wire low", bank[8'h06], 8'hFB);
    pulse_req();
    repeat (CYC + 6) @(negedge clk_i);
    check("R10 pulse width", hi_cyc - lo_cyc, CYC);
    check("R10 wire restored", bank[8'h06], 8'hFF);
    check("R11 request during pulse ignored", lo_n - l0, 1);
    pulse_req(); repeat (CYC + 6) @(negedge clk_i);
    check("R11 later request accepted", lo_n - l0, 2);

    // R12: startup during the low phase keeps the wire low
    rst0 = rst_n;
    pulse_req(); repeat (2) @(negedge clk_i);
    put(8'h03, 8'h72); raise(8'h02); repeat (3) @(negedge clk_i);
    check("R12 startup keeps wire low", bank[8'h06], 8'hFB);
    repeat (CYC) @(negedge clk_i);
    check("R12 timed release", bank[8'h06], 8'hFF);
    check("R12 pulse width kept", hi_cyc - lo_cyc, CYC);
    check("R8 no event on release during pulse", rst_n, rst0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule